// File: doc/BRIEF.md
# Ramp Offset Auto-Calibration Controller

A column-parallel converter that splits its reference into several concurrent ramps only stays linear if every ramp starts exactly where the one below it expects. Each ramp is produced by its own 12-bit DAC, so an offset between two ramps can be removed by moving the DAC code at which the upper ramp starts. This controller measures and removes those offsets one ramp at a time, using a dedicated test column whose input is driven from the ramp generator itself.

For ramp k (1 upward) the controller places the test column's input at the middle of ramp k−1's span. The coarse phase then picks ramp k−1 and the fine phase measures against ramp k. The controller asks the conversion sequencer for 2^N conversions and sums each fine result minus the ideal mid-span code in a signed accumulator. It divides the sum by an arithmetic right shift and adds the average to ramp k's start code, clamped to 0..4095. Ramp 0 is the fixed reference. Ramps are corrected in ascending order, so each measurement rests on an already corrected lower neighbour. A register port holds the start codes for software; it is read-only while a sweep runs.

Top module: `ramp_offset_cal`

## Requirements
- R1: After reset, `cal_busy`, `cal_done` and `conv_start` are 0, and the start code of ramp i reads back as i × RAMP_PITCH (96 by default).
- R2: While idle, a write on the register port (`reg_we` = 1 with `reg_addr` and `reg_wdata`) updates that ramp's start code. `reg_rdata` shows the code of the ramp at `reg_addr`, updated one cycle after the write.
- R3: A register-port write made while `cal_busy` = 1 has no effect on any start code.
- R4: A sweep calibrates ramps 1 through NUM_RAMPS−1 in ascending order. `cal_ramp` names the ramp under calibration, and it only stays or steps up by one while busy.
- R5: Each ramp receives exactly 2^N conversion requests. N is `avg_log2` captured at the start pulse; values above MAX_LOG2 (6) count as 6.
- R6: The new start code of ramp k is its old code plus floor(Σ(result − IDEAL_CODE) / 2^N), taken over that ramp's conversions. IDEAL_CODE defaults to 32.
- R7: A corrected start code is clamped to the range 0..4095.
- R8: While ramp k is calibrated, `test_level` equals min(code[k−1] + HALF_SPAN, 4095), using the already corrected code of ramp k−1. HALF_SPAN defaults to 128. `test_level` stays constant while a conversion is pending.
- R9: `cal_done` rises in the cycle `cal_busy` falls after the last ramp. It stays high until the next accepted `cal_start` and is cleared in the cycle after that start. A `cal_start` during a sweep is ignored. `cal_done` and `cal_busy` are never high together.
- R10: Ramp 0's start code is never changed by a sweep, and `cal_ramp` is never 0 while busy.
- R11: `conv_start` is a one-cycle pulse, raised only while busy. A new pulse is raised only after `conv_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Start pulse for a full sweep (taken only when idle) |
| avg_log2 | input | 3 | Log2 of conversions averaged per ramp, captured at start |
| cal_busy | output | 1 | Sweep in progress |
| cal_done | output | 1 | Sweep finished; held until the next start |
| cal_ramp | output | 3 | Index of the ramp being calibrated |
| test_level | output | 12 | DAC code for the test column input (mid-span of ramp k−1) |
| conv_start | output | 1 | Request one coarse+fine conversion from the sequencer |
| conv_done | input | 1 | Sequencer reports that the requested conversion finished |
| conv_result | input | 8 | Fine-phase result of the test column |
| reg_we | input | 1 | Start-code write strobe |
| reg_addr | input | 3 | Ramp index for read and write |
| reg_wdata | input | 12 | Start code to write |
| reg_rdata | output | 12 | Start code of the ramp at `reg_addr` |

## Verification
The bench builds the block with its defaults: eight ramps, 12-bit start codes, 8-bit fine results, MAX_LOG2 of 6, HALF_SPAN 128, IDEAL_CODE 32 and pitch 96. With these values a full seven-ramp sweep is exercised. Averaging depths of 1, 4, 32 and 64 conversions are run, and an out-of-range depth request is folded back to 64. A small bench model of the ramp offsets and of dither noise makes the truncating average visible as non-integer sums. Start codes of 0 and 4095 lie within reach of the offsets, so both clamp limits and the saturated test level are hit.

// File: rtl/ramp_cal_pkg.sv
// Shared types for the ramp offset calibration controller.
package ramp_cal_pkg;

    // Sweep controller states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // waiting for a start pulse
        ST_LOAD   = 3'd1,   // clear accumulator for the current ramp
        ST_REQ    = 3'd2,   // issue one conversion request
        ST_WAIT   = 3'd3,   // wait for the conversion to complete
        ST_UPDATE = 3'd4    // write the corrected start code
    } cal_state_e;

endpackage

// File: rtl/ramp_code_regs.sv
// Start-code register file: one DAC start code per ramp.
// Assumes NUM_RAMPS is a power of two so every index is a valid entry.
// The calibration write port has priority and never touches entry 0;
// the host write enable is expected to be gated off during a sweep.
module ramp_code_regs #(
    parameter int NUM_RAMPS  = 8,
    parameter int DAC_W      = 12,
    parameter int RAMP_PITCH = 96,
    localparam int IDX_W     = $clog2(NUM_RAMPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_addr,
    input  logic [DAC_W-1:0] host_wdata,
    input  logic             cal_we,
    input  logic [IDX_W-1:0] cal_idx,
    input  logic [DAC_W-1:0] cal_wdata,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [DAC_W-1:0] rd_data,
    input  logic [IDX_W-1:0] ref_idx,
    output logic [DAC_W-1:0] ref_code,
    output logic [DAC_W-1:0] tgt_code
);

    logic [DAC_W-1:0] code_q [NUM_RAMPS];

    // Storage update: reset to an evenly spaced ladder, then cal or host writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_RAMPS; i++) begin
            if (!rst_n) begin
                code_q[i] <= DAC_W'(i * RAMP_PITCH);
            end else if (cal_we && (i != 0) && (cal_idx == IDX_W'(i))) begin
                code_q[i] <= cal_wdata;
            end else if (host_we && (host_addr == IDX_W'(i))) begin
                code_q[i] <= host_wdata;
            end
        end
    end

    // Read ports: host view, reference ramp (k-1) and target ramp (k).
    always_comb begin
        rd_data  = code_q[rd_addr];
        ref_code = code_q[ref_idx];
        tgt_code = code_q[cal_idx];
    end

endmodule

// File: rtl/ramp_err_accum.sv
// Error accumulator and correction arithmetic.
// Sums signed (sample - IDEAL_CODE) over up to 2^MAX_LOG2 conversions,
// averages by an arithmetic right shift (floor), and produces the
// clamped corrected start code cur_code + average.
module ramp_err_accum #(
    parameter int FINE_W     = 8,
    parameter int DAC_W      = 12,
    parameter int IDEAL_CODE = 32,
    parameter int MAX_LOG2   = 6,
    parameter int AVG_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [FINE_W-1:0] sample,
    input  logic [AVG_W-1:0]  shift_n,
    input  logic [DAC_W-1:0]  cur_code,
    output logic [DAC_W-1:0]  new_code
);

    localparam int ERR_W = FINE_W + 1;
    localparam int ACC_W = ERR_W + MAX_LOG2;
    localparam int SUM_W = ((DAC_W > ACC_W) ? DAC_W : ACC_W) + 2;
    localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << DAC_W) - 1);

    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] avg;
    logic signed [SUM_W-1:0] sum;

    // Signed deviation of one fine result from the ideal mid-span code.
    always_comb err = $signed({1'b0, sample}) - $signed(ERR_W'(IDEAL_CODE));

    // Running sum of deviations, cleared at the start of each ramp.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
        end
    end

    // Average (floor) and clamped corrected code.
    always_comb begin
        avg = acc_q >>> shift_n;
        sum = $signed({{(SUM_W-DAC_W){1'b0}}, cur_code})
            + $signed({{(SUM_W-ACC_W){avg[ACC_W-1]}}, avg});
        if (sum[SUM_W-1]) begin
            new_code = '0;
        end else if (sum > CODE_MAX) begin
            new_code = '1;
        end else begin
            new_code = sum[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/ramp_cal_seq.sv
// Sweep sequencer: walks ramps 1..NUM_RAMPS-1 in ascending order and,
// per ramp, issues 2^N conversion requests one at a time, then commands
// the start-code update. N is captured at the start pulse and saturated
// to MAX_LOG2. Assumes MAX_LOG2 >= 1 and conv_done only answers a request.
module ramp_cal_seq
    import ramp_cal_pkg::*;
#(
    parameter int NUM_RAMPS = 8,
    parameter int MAX_LOG2  = 6,
    parameter int AVG_W     = 3,
    localparam int IDX_W    = $clog2(NUM_RAMPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start,
    input  logic [AVG_W-1:0] avg_log2,
    input  logic             conv_done,
    output logic             conv_start,
    output logic             acc_clr,
    output logic             acc_add,
    output logic             code_we,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] cal_idx,
    output logic [AVG_W-1:0] shift_n
);

    localparam int CNT_W = MAX_LOG2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RAMPS - 1);
    localparam logic [AVG_W-1:0] N_MAX    = AVG_W'(MAX_LOG2);

    cal_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_lim;
    logic [AVG_W-1:0] n_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    // Last conversion index for the captured averaging depth.
    always_comb cnt_lim = {CNT_W{1'b1}} >> (N_MAX - n_q);

    // Sweep state machine with per-ramp conversion counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            n_q     <= '0;
            idx_q   <= IDX_W'(1);
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cal_start) begin
                        n_q     <= (avg_log2 > N_MAX) ? N_MAX : avg_log2;
                        idx_q   <= IDX_W'(1);
                        done_q  <= 1'b0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cnt_q   <= '0;
                    state_q <= ST_REQ;
                end
                ST_REQ: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (cnt_q == cnt_lim) begin
                            state_q <= ST_UPDATE;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_UPDATE: begin
                    if (idx_q == LAST_IDX) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_LOAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // State decode to control strobes.
    always_comb begin
        conv_start = (state_q == ST_REQ);
        acc_clr    = (state_q == ST_LOAD);
        acc_add    = (state_q == ST_WAIT) && conv_done;
        code_we    = (state_q == ST_UPDATE);
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        cal_idx    = idx_q;
        shift_n    = n_q;
    end

endmodule

// File: rtl/ramp_offset_cal.sv
// Ramp offset auto-calibration controller (top).
// Drives the test column to the middle of ramp k-1, averages the fine
// deviation measured against ramp k and folds it into ramp k's start code.
// Assumes HALF_SPAN < 2^DAC_W and a power-of-two NUM_RAMPS.
module ramp_offset_cal #(
    parameter int NUM_RAMPS  = 8,
    parameter int DAC_W      = 12,
    parameter int FINE_W     = 8,
    parameter int MAX_LOG2   = 6,
    parameter int HALF_SPAN  = 128,
    parameter int IDEAL_CODE = 32,
    parameter int RAMP_PITCH = 96,
    localparam int IDX_W     = $clog2(NUM_RAMPS),
    localparam int AVG_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic [AVG_W-1:0]  avg_log2,
    output logic              cal_busy,
    output logic              cal_done,
    output logic [IDX_W-1:0]  cal_ramp,
    output logic [DAC_W-1:0]  test_level,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [FINE_W-1:0] conv_result,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [DAC_W-1:0]  reg_wdata,
    output logic [DAC_W-1:0]  reg_rdata
);

    logic             acc_clr;
    logic             acc_add;
    logic             code_we;
    logic [IDX_W-1:0] cal_idx;
    logic [AVG_W-1:0] shift_n;
    logic [DAC_W-1:0] ref_code;
    logic [DAC_W-1:0] tgt_code;
    logic [DAC_W-1:0] new_code;
    logic [DAC_W:0]   tl_sum;

    ramp_cal_seq #(
        .NUM_RAMPS (NUM_RAMPS),
        .MAX_LOG2  (MAX_LOG2),
        .AVG_W     (AVG_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_start  (cal_start),
        .avg_log2   (avg_log2),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .acc_clr    (acc_clr),
        .acc_add    (acc_add),
        .code_we    (code_we),
        .busy       (cal_busy),
        .done       (cal_done),
        .cal_idx    (cal_idx),
        .shift_n    (shift_n)
    );

    ramp_err_accum #(
        .FINE_W     (FINE_W),
        .DAC_W      (DAC_W),
        .IDEAL_CODE (IDEAL_CODE),
        .MAX_LOG2   (MAX_LOG2),
        .AVG_W      (AVG_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add      (acc_add),
        .sample   (conv_result),
        .shift_n  (shift_n),
        .cur_code (tgt_code),
        .new_code (new_code)
    );

    ramp_code_regs #(
        .NUM_RAMPS  (NUM_RAMPS),
        .DAC_W      (DAC_W),
        .RAMP_PITCH (RAMP_PITCH)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (reg_we && !cal_busy),
        .host_addr  (reg_addr),
        .host_wdata (reg_wdata),
        .cal_we     (code_we),
        .cal_idx    (cal_idx),
        .cal_wdata  (new_code),
        .rd_addr    (reg_addr),
        .rd_data    (reg_rdata),
        .ref_idx    (cal_idx - 1'b1),
        .ref_code   (ref_code),
        .tgt_code   (tgt_code)
    );

    // Test column level: mid-span of the lower ramp, saturated at full scale.
    always_comb begin
        tl_sum     = {1'b0, ref_code} + (DAC_W + 1)'(HALF_SPAN);
        test_level = tl_sum[DAC_W] ? '1 : tl_sum[DAC_W-1:0];
        cal_ramp   = cal_idx;
    end

endmodule

// File: rtl/ramp_offset_cal_chk.sv
// Protocol and ordering checker for ramp_offset_cal, bound to the top.
module ramp_offset_cal_chk #(
    parameter int IDX_W = 3,
    parameter int DAC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_start,
    input logic             cal_busy,
    input logic             cal_done,
    input logic [IDX_W-1:0] cal_ramp,
    input logic [DAC_W-1:0] test_level,
    input logic             conv_start,
    input logic             conv_done
);

    logic pending_q;

    // Tracks a request that has not yet been answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (conv_start) begin
            pending_q <= 1'b1;
        end else if (conv_done) begin
            pending_q <= 1'b0;
        end
    end

    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pending_q);
    assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> cal_busy);
    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !cal_busy);
    assert_done_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(cal_busy));
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_start) |=> cal_done);
    assert_ramp_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (cal_ramp != '0));
    assert_ramp_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && $past(cal_busy) && (cal_ramp != $past(cal_ramp)))
        |-> (cal_ramp == $past(cal_ramp) + 1'b1));
    assert_level_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && $past(pending_q)) |-> $stable(test_level));

endmodule

bind ramp_offset_cal ramp_offset_cal_chk #(
    .IDX_W (IDX_W),
    .DAC_W (DAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_start  (cal_start),
    .cal_busy   (cal_busy),
    .cal_done   (cal_done),
    .cal_ramp   (cal_ramp),
    .test_level (test_level),
    .conv_start (conv_start),
    .conv_done  (conv_done)
);

// File: tb/ramp_offset_cal_tb.sv
module ramp_offset_cal_tb;

    localparam int NUM   = 8;
    localparam int HALF  = 128;
    localparam int IDEAL = 32;
    localparam int PITCH = 96;
    localparam int LAT   = 2;

    // Scenario table: {avg_log2 driven, expected effective N, offset profile}
    localparam int SCEN [4][3] = '{'{0, 0, 0}, '{2, 2, 1}, '{5, 5, 2}, '{7, 6, 1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic [2:0]  avg_log2 = 3'd0;
    logic        cal_busy, cal_done, conv_start;
    logic [2:0]  cal_ramp;
    logic [11:0] test_level, reg_rdata;
    logic        conv_done = 1'b0;
    logic [7:0]  conv_result = 8'd0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [11:0] reg_wdata = 12'd0;

    int n_chk = 0;
    int n_err = 0;
    int mirror [NUM];
    int offs [NUM];
    int n_eff = 0;
    int req_cnt = 0;
    int sum_acc = 0;

    always #2.5 clk = ~clk;

    ramp_offset_cal u_dut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .avg_log2(avg_log2),
        .cal_busy(cal_busy), .cal_done(cal_done), .cal_ramp(cal_ramp),
        .test_level(test_level), .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp12(input int v);
        return (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
    endfunction

    function automatic int noise(input int j);
        return ((j * 7) % 5) - 2;
    endfunction

    function automatic int offp(input int p, input int k);
        case (p)
            1: return k * 3 - 10;
            2: return (k % 2) ? 7 : -5;
            3: return (k == 0) ? 0 : 120;
            4: return (k == 0) ? 0 : -100;
            default: return 0;
        endcase
    endfunction

    // Conversion sequencer and analog model of the test column.
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start) begin
                int r, j, res;
                r = (req_cnt >> n_eff) + 1;
                j = req_cnt & ((1 << n_eff) - 1);
                req_cnt++;
                if (r >= NUM) begin
                    chk("R5 extra request ramp", r, NUM - 1);
                end else begin
                    if (j == 0) sum_acc = 0;
                    chk("R4 cal_ramp order", int'(cal_ramp), r);
                    chk("R8 test_level", int'(test_level), clamp12(mirror[r-1] + HALF));
                    res = int'(test_level) + offs[r-1] - mirror[r] - offs[r] + noise(j);
                    res = (res < 0) ? 0 : ((res > 255) ? 255 : res);
                    sum_acc += res - IDEAL;
                    if (j == (1 << n_eff) - 1) mirror[r] = clamp12(mirror[r] + (sum_acc >>> n_eff));
                    @(negedge clk);
                    chk("R11 one-cycle request", int'(conv_start), 0);
                    repeat (LAT - 1) @(negedge clk);
                    conv_done   = 1'b1;
                    conv_result = 8'(res);
                end
            end
        end
    end

    task automatic rd(input int a, output int v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 12'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load_all(input int base, input int step, input int prof);
        for (int i = 0; i < NUM; i++) begin
            mirror[i] = clamp12(base + i * step);
            offs[i]   = offp(prof, i);
            wr(i, mirror[i]);
        end
    endtask

    task automatic run_cal(input int avg_in, input int neff);
        int v;
        n_eff = neff; req_cnt = 0;
        @(negedge clk);
        cal_start = 1'b1; avg_log2 = 3'(avg_in);
        @(negedge clk);
        cal_start = 1'b0;
        chk("R9 done cleared after start", int'(cal_done), 0);
        chk("R9 busy after start", int'(cal_busy), 1);
        repeat (3) @(negedge clk);
        // write attempt and second start while busy: both ignored
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 12'd777; cal_start = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; cal_start = 1'b0;
        while (cal_busy) @(negedge clk);
        chk("R9 done at end", int'(cal_done), 1);
        chk("R5 request count", req_cnt, (NUM - 1) << neff);
        for (int i = 1; i < NUM; i++) begin
            rd(i, v);
            chk("R6 corrected code", v, mirror[i]);
        end
        rd(0, v);
        chk("R3 R10 ramp0 untouched", v, mirror[0]);
        repeat (3) @(negedge clk);
        chk("R9 done held", int'(cal_done), 1);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R5: actual=running expected=finished");
        report();
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", int'(cal_busy), 0);
        chk("R1 done in reset", int'(cal_done), 0);
        chk("R1 conv_start in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NUM; i++) begin
            rd(i, v);
            chk("R1 reset code", v, i * PITCH);
        end
        wr(3, 1234);
        rd(3, v);
        chk("R2 write readback", v, 1234);
        rd(2, v);
        chk("R2 neighbour unchanged", v, 2 * PITCH);

        for (int s = 0; s < 4; s++) begin
            load_all(0, PITCH, SCEN[s][2]);
            run_cal(SCEN[s][0], SCEN[s][1]);
        end

        // low clamp: ramp 1 starts far too high
        load_all(0, 0, 3);
        run_cal(1, 1);
        rd(1, v);
        chk("R7 low clamp", v, 0);

        // high clamp and saturated test level
        load_all(4095, 0, 4);
        run_cal(1, 1);
        rd(1, v);
        chk("R7 high clamp", v, 4095);

        report();
    end

endmodule